// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state update a processor core makes at the moment it takes an exception. A pipeline front end presents a single-cycle strobe with a primary code, a subcode, the interrupt line that won arbitration, the PC and the faulting instruction word. It also presents a refill flag and the live mode bits, the debug-state bit, the vector-size field and two entry bases. On the next clock edge the block commits, in one step, the redirect PC, the new mode bits and every save register the entry writes. It raises a one-cycle `commit` pulse so that the control register file can load the new mode and PC.

There are three paths.

- **Normal entry** saves the mode into the saved-mode register and the PC into the return register, and records the codes.
- **Refill entry** uses its own saved-mode and return registers, switches to direct addressing and jumps to a separate base.
- **Debug entry** is taken for a breakpoint, or for an interrupt that arrives while already in debug state. It saves the PC into the debug return register and jumps to a fixed offset from the entry base.

Vector spacing comes from the vector-size field. A zero field collapses every vector onto the base.

Primary code encoding (decimal):

| Code | Meaning |
|---|---|
| 0 | interrupt |
| 1 | load page invalid |
| 2 | store page invalid |
| 3 | fetch page invalid |
| 4 | page modified |
| 5 | not readable |
| 6 | not executable |
| 7 | page privilege |
| 8 | fetch address error |
| 9 | memory address error |
| 10 | bound check |
| 11 | syscall |
| 12 | break |
| 13 | reserved instruction |
| 14 | privileged instruction |
| 15 | FP disabled |
| 16 | vector disabled |
| 17 | FP exception |
| 18 | debug breakpoint |

Codes above 18 are unsupported.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `commit`, `badCode`, `newPc`, all mode, saved-mode, status, address, instruction and debug outputs are 0, except `nxtDa` which is 1.
- R2: A strobe with a supported code produces `commit`=1 in the next cycle (one cycle only), with `nxtPlv`=0 and `nxtIe`=0; on a non-refill, non-debug entry `savedPlv`/`savedIe` take `curPlv`/`curIe`.
- R3: On a non-debug entry with `refill`=1, `rfSavedPlv`/`rfSavedIe` take `curPlv`/`curIe`, `nxtDa`=1, `nxtPg`=0, `rfRetAddr`=`curPc`>>2, and for a code other than 0 `newPc`=`refillBase`; `savedPlv`, `savedIe`, `statCode`, `statSub` and `retAddr` keep their values. Without refill `nxtDa`/`nxtPg` follow `curDa`/`curPg`.
- R4: On a non-refill, non-debug entry `statCode`=`excCode`, `statSub`=`excSub` and `retAddr`=`curPc`.
- R5: Codes 11 to 17 write `curPc` into `badAddr`; every other code leaves it unchanged.
- R6: Every supported code except 0, 3 and 8 copies `instWord` into `badInstr`; those three leave it unchanged.
- R7: Code 18 sets `dbgCauseBp`, writes 0xC into `dbgCodeOut`, stores `curPc` in `dbgRetAddr`, sets `dbgState` and gives `newPc`=`excBase`+0x480, leaving the normal and refill save registers unchanged.
- R8: Code 0 while `dbgActive`=1 sets `dbgCauseInt`, stores `curPc` in `dbgRetAddr`, sets `dbgState` and gives `newPc`=`excBase`+0x480, regardless of `refill`, without touching the normal or refill save registers.
- R9: A non-refill, non-debug entry with a nonzero code gives `newPc`=`excBase`+code×spacing, where spacing is 4·2^`vecSize` for a nonzero `vecSize` and 0 when `vecSize`=0.
- R10: An interrupt on the normal or refill path gives `newPc`=`excBase`+(64+`irqLine`)×spacing.
- R11: A strobe with a code above 18 gives `badCode`=1 for one cycle, `commit`=0, and changes no other output.
- R12: Without a strobe every output except the `commit` and `badCode` pulses holds its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| excValid | input | 1 | Exception strobe, one cycle |
| excCode | input | 6 | Primary code |
| excSub | input | 9 | Subcode |
| irqLine | input | 5 | Winning interrupt line |
| curPc | input | 32 | PC of the excepting instruction |
| instWord | input | 32 | Faulting instruction word |
| refill | input | 1 | Take the refill path |
| curPlv | input | 2 | Current privilege level |
| curIe | input | 1 | Current interrupt enable |
| curDa | input | 1 | Current direct-address bit |
| curPg | input | 1 | Current paging bit |
| dbgActive | input | 1 | Core is already in debug state |
| vecSize | input | 3 | Vector-size field |
| excBase | input | 32 | Exception entry base |
| refillBase | input | 32 | Refill entry base |
| commit | output | 1 | Entry committed last edge |
| badCode | output | 1 | Unsupported code seen last edge |
| newPc | output | 32 | Redirect PC |
| nxtPlv | output | 2 | New privilege level |
| nxtIe | output | 1 | New interrupt enable |
| nxtDa | output | 1 | New direct-address bit |
| nxtPg | output | 1 | New paging bit |
| savedPlv | output | 2 | Normal saved privilege |
| savedIe | output | 1 | Normal saved interrupt enable |
| rfSavedPlv | output | 2 | Refill saved privilege |
| rfSavedIe | output | 1 | Refill saved interrupt enable |
| statCode | output | 6 | Recorded primary code |
| statSub | output | 9 | Recorded subcode |
| retAddr | output | 32 | Normal return address |
| rfRetAddr | output | 32 | Refill return, PC>>2 |
| badAddr | output | 32 | Bad-address register |
| badInstr | output | 32 | Captured instruction word |
| dbgRetAddr | output | 32 | Debug return address |
| dbgState | output | 1 | Debug state entered |
| dbgCauseBp | output | 1 | Debug cause: breakpoint |
| dbgCauseInt | output | 1 | Debug cause: interrupt |
| dbgCodeOut | output | 6 | Debug code field |

## Verification
The bench builds the block with its defaults: a 32-bit address width, a 5-bit interrupt line and an interrupt vector base of 64. The vector-size field is driven at 0, 1, 2, 3 and 7. With 7 the spacing reaches 512 bytes and the interrupt vector offset reaches bit 15, which exercises the widest shift the default width must carry without truncation. Refill is applied both with and without an interrupt, and both debug causes are taken back to back. Each redirect therefore comes from a different base and offset combination.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 6;
  localparam int SUB_W  = 9;

  localparam logic [CODE_W-1:0] EC_IRQ    = 6'd0;
  localparam logic [CODE_W-1:0] EC_FEPG   = 6'd3;
  localparam logic [CODE_W-1:0] EC_FEADR  = 6'd8;
  localparam logic [CODE_W-1:0] EC_SYSC   = 6'd11;
  localparam logic [CODE_W-1:0] EC_FPERR  = 6'd17;
  localparam logic [CODE_W-1:0] EC_DBGBP  = 6'd18;
  localparam logic [CODE_W-1:0] DBG_BP_CODE = 6'hC;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic reject;
    logic toDebug;
    logic dbgBp;
    logic dbgIrq;
    logic toRefill;
    logic isIrq;
    logic wrBadAddr;
    logic wrBadInstr;
  } entryCtlT;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              refill,
  input  logic              dbgActive,
  output entryCtlT          ctl
);
  logic legal;

  always_comb begin
    legal          = (excCode <= EC_DBGBP);
    ctl            = '0;
    ctl.take       = excValid & legal;
    ctl.reject     = excValid & ~legal;
    ctl.isIrq      = (excCode == EC_IRQ);
    ctl.dbgBp      = (excCode == EC_DBGBP);
    ctl.dbgIrq     = ctl.isIrq & dbgActive;
    ctl.toDebug    = ctl.dbgBp | ctl.dbgIrq;
    ctl.toRefill   = refill & ~ctl.toDebug;
    // instruction-class faults record the PC as bad address
    ctl.wrBadAddr  = (excCode >= EC_SYSC) && (excCode <= EC_FPERR);
    // fetch-side faults and interrupts have no instruction to capture
    ctl.wrBadInstr = legal && !(ctl.isIrq || excCode == EC_FEPG || excCode == EC_FEADR);
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IRQ_W      = 5,
  parameter int VS_W       = 3,
  parameter int IRQ_BASE   = 64,
  parameter int DBG_OFFSET = 'h480
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryCtlT          ctl,
  input  logic [CODE_W-1:0] excCode,
  input  logic [SUB_W-1:0]  excSub,
  input  logic [IRQ_W-1:0]  irqLine,
  input  logic [XLEN-1:0]   curPc,
  input  logic [31:0]       instWord,
  input  logic [1:0]        curPlv,
  input  logic              curIe,
  input  logic              curDa,
  input  logic              curPg,
  input  logic [VS_W-1:0]   vecSize,
  input  logic [XLEN-1:0]   excBase,
  input  logic [XLEN-1:0]   refillBase,
  output logic              commit,
  output logic              badCode,
  output logic [XLEN-1:0]   newPc,
  output logic [1:0]        nxtPlv,
  output logic              nxtIe,
  output logic              nxtDa,
  output logic              nxtPg,
  output logic [1:0]        savedPlv,
  output logic              savedIe,
  output logic [1:0]        rfSavedPlv,
  output logic              rfSavedIe,
  output logic [CODE_W-1:0] statCode,
  output logic [SUB_W-1:0]  statSub,
  output logic [XLEN-1:0]   retAddr,
  output logic [XLEN-1:0]   rfRetAddr,
  output logic [XLEN-1:0]   badAddr,
  output logic [31:0]       badInstr,
  output logic [XLEN-1:0]   dbgRetAddr,
  output logic              dbgState,
  output logic              dbgCauseBp,
  output logic              dbgCauseInt,
  output logic [CODE_W-1:0] dbgCodeOut
);
  localparam int SH_W = VS_W + 2;

  logic [XLEN-1:0] vecIdx;
  logic [XLEN-1:0] vecOff;
  logic [SH_W-1:0] shAmt;
  logic [XLEN-1:0] target;

  always_comb begin
    vecIdx = ctl.isIrq ? (XLEN'(IRQ_BASE) + XLEN'(irqLine)) : XLEN'(excCode);
    shAmt  = SH_W'(vecSize) + SH_W'(2);
    vecOff = (vecSize != '0) ? (vecIdx << shAmt) : '0;
    if (ctl.toDebug)
      target = excBase + XLEN'(DBG_OFFSET);
    else if (ctl.toRefill && !ctl.isIrq)
      target = refillBase;
    else
      target = excBase + vecOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commit      <= 1'b0;
      badCode     <= 1'b0;
      newPc       <= '0;
      nxtPlv      <= '0;
      nxtIe       <= 1'b0;
      nxtDa       <= 1'b1;
      nxtPg       <= 1'b0;
      savedPlv    <= '0;
      savedIe     <= 1'b0;
      rfSavedPlv  <= '0;
      rfSavedIe   <= 1'b0;
      statCode    <= '0;
      statSub     <= '0;
      retAddr     <= '0;
      rfRetAddr   <= '0;
      badAddr     <= '0;
      badInstr    <= '0;
      dbgRetAddr  <= '0;
      dbgState    <= 1'b0;
      dbgCauseBp  <= 1'b0;
      dbgCauseInt <= 1'b0;
      dbgCodeOut  <= '0;
    end else begin
      commit  <= ctl.take;
      badCode <= ctl.reject;
      if (ctl.take) begin
        newPc  <= target;
        nxtPlv <= '0;
        nxtIe  <= 1'b0;
        nxtDa  <= ctl.toRefill ? 1'b1 : curDa;
        nxtPg  <= ctl.toRefill ? 1'b0 : curPg;
        if (ctl.toDebug) begin
          dbgRetAddr <= curPc;
          dbgState   <= 1'b1;
          if (ctl.dbgBp) begin
            dbgCauseBp <= 1'b1;
            dbgCodeOut <= DBG_BP_CODE;
          end
          if (ctl.dbgIrq) dbgCauseInt <= 1'b1;
        end else if (ctl.toRefill) begin
          rfSavedPlv <= curPlv;
          rfSavedIe  <= curIe;
          rfRetAddr  <= curPc >> 2;
        end else begin
          savedPlv <= curPlv;
          savedIe  <= curIe;
          statCode <= excCode;
          statSub  <= excSub;
          retAddr  <= curPc;
        end
        if (ctl.wrBadAddr)  badAddr  <= curPc;
        if (ctl.wrBadInstr) badInstr <= instWord;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IRQ_W      = 5,
  parameter int VS_W       = 3,
  parameter int IRQ_BASE   = 64,
  parameter int DBG_OFFSET = 'h480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic [SUB_W-1:0]  excSub,
  input  logic [IRQ_W-1:0]  irqLine,
  input  logic [XLEN-1:0]   curPc,
  input  logic [31:0]       instWord,
  input  logic              refill,
  input  logic [1:0]        curPlv,
  input  logic              curIe,
  input  logic              curDa,
  input  logic              curPg,
  input  logic              dbgActive,
  input  logic [VS_W-1:0]   vecSize,
  input  logic [XLEN-1:0]   excBase,
  input  logic [XLEN-1:0]   refillBase,
  output logic              commit,
  output logic              badCode,
  output logic [XLEN-1:0]   newPc,
  output logic [1:0]        nxtPlv,
  output logic              nxtIe,
  output logic              nxtDa,
  output logic              nxtPg,
  output logic [1:0]        savedPlv,
  output logic              savedIe,
  output logic [1:0]        rfSavedPlv,
  output logic              rfSavedIe,
  output logic [CODE_W-1:0] statCode,
  output logic [SUB_W-1:0]  statSub,
  output logic [XLEN-1:0]   retAddr,
  output logic [XLEN-1:0]   rfRetAddr,
  output logic [XLEN-1:0]   badAddr,
  output logic [31:0]       badInstr,
  output logic [XLEN-1:0]   dbgRetAddr,
  output logic              dbgState,
  output logic              dbgCauseBp,
  output logic              dbgCauseInt,
  output logic [CODE_W-1:0] dbgCodeOut
);
  entryCtlT ctl;

  exc_entry_ctrl u_ctrl (
    .excValid (excValid),
    .excCode  (excCode),
    .refill   (refill),
    .dbgActive(dbgActive),
    .ctl      (ctl)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .IRQ_W(IRQ_W), .VS_W(VS_W),
    .IRQ_BASE(IRQ_BASE), .DBG_OFFSET(DBG_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .excCode(excCode), .excSub(excSub), .irqLine(irqLine),
    .curPc(curPc), .instWord(instWord),
    .curPlv(curPlv), .curIe(curIe), .curDa(curDa), .curPg(curPg),
    .vecSize(vecSize), .excBase(excBase), .refillBase(refillBase),
    .commit(commit), .badCode(badCode), .newPc(newPc),
    .nxtPlv(nxtPlv), .nxtIe(nxtIe), .nxtDa(nxtDa), .nxtPg(nxtPg),
    .savedPlv(savedPlv), .savedIe(savedIe),
    .rfSavedPlv(rfSavedPlv), .rfSavedIe(rfSavedIe),
    .statCode(statCode), .statSub(statSub),
    .retAddr(retAddr), .rfRetAddr(rfRetAddr),
    .badAddr(badAddr), .badInstr(badInstr), .dbgRetAddr(dbgRetAddr),
    .dbgState(dbgState), .dbgCauseBp(dbgCauseBp), .dbgCauseInt(dbgCauseInt),
    .dbgCodeOut(dbgCodeOut)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            excValid,
  input logic [5:0]      excCode,
  input logic            refill,
  input logic            dbgActive,
  input logic [XLEN-1:0] curPc,
  input logic [XLEN-1:0] excBase,
  input logic            commit,
  input logic            badCode,
  input logic [1:0]      nxtPlv,
  input logic            nxtIe,
  input logic            nxtDa,
  input logic            nxtPg,
  input logic [XLEN-1:0] retAddr,
  input logic [XLEN-1:0] newPc,
  input logic            dbgState,
  input logic            dbgCauseBp,
  input logic [5:0]      dbgCodeOut
);
  assert_commit_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> $past(excValid));

  assert_mode_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (nxtPlv == 2'd0 && !nxtIe));

  assert_refill_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    (commit && $past(refill) && $past(excCode) != 6'd18
       && !($past(excCode) == 6'd0 && $past(dbgActive)))
    |-> (nxtDa && !nxtPg));

  assert_ret_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !$past(refill) && $past(excCode) != 6'd18
       && !($past(excCode) == 6'd0 && $past(dbgActive)))
    |-> (retAddr == $past(curPc)));

  assert_breakpoint_R7: assert property (@(posedge clk) disable iff (!rstN)
    (commit && $past(excCode) == 6'd18)
    |-> (dbgState && dbgCauseBp && dbgCodeOut == 6'hC
         && newPc == $past(excBase) + XLEN'('h480)));

  assert_reject_R11: assert property (@(posedge clk) disable iff (!rstN)
    badCode |-> !commit);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(excValid) |-> ($stable(newPc) && $stable(retAddr)));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode),
  .refill(refill), .dbgActive(dbgActive), .curPc(curPc), .excBase(excBase),
  .commit(commit), .badCode(badCode), .nxtPlv(nxtPlv), .nxtIe(nxtIe),
  .nxtDa(nxtDa), .nxtPg(nxtPg), .retAddr(retAddr), .newPc(newPc),
  .dbgState(dbgState), .dbgCauseBp(dbgCauseBp), .dbgCodeOut(dbgCodeOut)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  localparam logic [31:0] EB = 32'h1C00_0000;
  localparam logic [31:0] RB = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic excValid = 0; logic [5:0] excCode = 0; logic [8:0] excSub = 0;
  logic [4:0] irqLine = 0; logic [31:0] curPc = 0; logic [31:0] instWord = 0;
  logic refill = 0; logic [1:0] curPlv = 0; logic curIe = 0;
  logic curDa = 0; logic curPg = 1; logic dbgActive = 0;
  logic [2:0] vecSize = 0; logic [31:0] excBase = EB; logic [31:0] refillBase = RB;

  logic commit, badCode, nxtIe, nxtDa, nxtPg, savedIe, rfSavedIe;
  logic dbgState, dbgCauseBp, dbgCauseInt;
  logic [1:0] nxtPlv, savedPlv, rfSavedPlv;
  logic [5:0] statCode, dbgCodeOut; logic [8:0] statSub;
  logic [31:0] newPc, retAddr, rfRetAddr, badAddr, badInstr, dbgRetAddr;

  exc_entry_seq uut (.*);

  typedef struct {
    string lbl;
    logic commit, badCode; logic [31:0] newPc;
    logic [1:0] plv; logic ie, da, pg;
    logic [1:0] sPlv; logic sIe; logic [1:0] rPlv; logic rIe;
    logic [5:0] sc; logic [8:0] ss;
    logic [31:0] ret, rfRet, bad, bi, dret;
    logic dst, dbp, dint; logic [5:0] dcode;
  } expT;

  expT q[$];
  expT m;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string tag, string lbl, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h", tag, lbl, act, expv);
    end
  endtask

  task automatic compare(expT e);
    chk("R2 commit", e.lbl, 32'(commit), 32'(e.commit));
    chk("R11 badCode", e.lbl, 32'(badCode), 32'(e.badCode));
    chk("R9 newPc", e.lbl, newPc, e.newPc);
    chk("R2 nxtPlv/Ie", e.lbl, {nxtPlv, nxtIe}, {e.plv, e.ie});
    chk("R3 nxtDa/Pg", e.lbl, {nxtDa, nxtPg}, {e.da, e.pg});
    chk("R2 saved mode", e.lbl, {savedPlv, savedIe}, {e.sPlv, e.sIe});
    chk("R3 refill saved", e.lbl, {rfSavedPlv, rfSavedIe}, {e.rPlv, e.rIe});
    chk("R4 status", e.lbl, {statCode, statSub}, {e.sc, e.ss});
    chk("R4 retAddr", e.lbl, retAddr, e.ret);
    chk("R3 rfRetAddr", e.lbl, rfRetAddr, e.rfRet);
    chk("R5 badAddr", e.lbl, badAddr, e.bad);
    chk("R6 badInstr", e.lbl, badInstr, e.bi);
    chk("R7 dbgRetAddr", e.lbl, dbgRetAddr, e.dret);
    chk("R7 dbg flags", e.lbl, {dbgState, dbgCauseBp, dbgCodeOut}, {e.dst, e.dbp, e.dcode});
    chk("R8 dbgCauseInt", e.lbl, 32'(dbgCauseInt), 32'(e.dint));
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(string lbl, bit v, int code, int sub, int line,
                       logic [31:0] pc, bit rf, int plv, bit ie, bit dbg, int vs);
    bit isIrq, bp, toD, toR;
    logic [31:0] idx, sp;
    @(negedge clk);
    excValid = v; excCode = 6'(code); excSub = 9'(sub); irqLine = 5'(line);
    curPc = pc; instWord = pc ^ 32'hA5A5_0000; refill = rf;
    curPlv = 2'(plv); curIe = ie; dbgActive = dbg; vecSize = 3'(vs);
    m.lbl = lbl; m.commit = 0; m.badCode = 0;
    if (v && code > 18) m.badCode = 1;
    else if (v) begin
      isIrq = (code == 0); bp = (code == 18);
      toD = bp || (isIrq && dbg); toR = rf && !toD;
      m.commit = 1; m.plv = 0; m.ie = 0;
      if (toD) begin
        m.dret = pc; m.dst = 1;
        if (bp) begin m.dbp = 1; m.dcode = 6'hC; end else m.dint = 1;
        m.newPc = EB + 32'h480; m.da = curDa; m.pg = curPg;
      end else begin
        if (toR) begin
          m.rPlv = 2'(plv); m.rIe = ie; m.da = 1; m.pg = 0; m.rfRet = pc >> 2;
        end else begin
          m.sPlv = 2'(plv); m.sIe = ie; m.sc = 6'(code); m.ss = 9'(sub);
          m.ret = pc; m.da = curDa; m.pg = curPg;
        end
        idx = isIrq ? 32'(64 + line) : 32'(code);
        sp = (vs == 0) ? 32'd0 : (32'd4 << vs);
        m.newPc = (toR && !isIrq) ? RB : EB + idx * sp;
      end
      if (code >= 11 && code <= 17) m.bad = pc;
      if (!(code == 0 || code == 3 || code == 8)) m.bi = pc ^ 32'hA5A5_0000;
    end
    q.push_back(m);
  endtask

  // monitor: compares queued expectations just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m = '{lbl: "reset", da: 1'b1, default: '0};
    repeat (3) @(posedge clk);
    #1;
    compare(m);                     // R1 reset state
    @(negedge clk); rstN = 1'b1;
    drive("R2 R4 R5 R6 syscall vs0", 1, 11, 5, 0, 32'h0000_1230, 0, 3, 1, 0, 0);
    drive("R9 load fault vs2", 1, 1, 0, 0, 32'h0000_2000, 0, 2, 0, 0, 2);
    drive("R6 fetch addr no capture", 1, 8, 1, 0, 32'h0000_3004, 0, 1, 1, 0, 1);
    drive("R3 refill fetch page", 1, 3, 0, 0, 32'h0000_400C, 1, 3, 1, 0, 1);
    drive("R3 R5 refill reserved vs3", 1, 13, 0, 0, 32'h0000_5010, 1, 2, 0, 0, 3);
    drive("R10 irq line5 vs1", 1, 0, 0, 5, 32'h0000_6000, 0, 1, 1, 0, 1);
    drive("R10 R3 irq refill vs2", 1, 0, 0, 31, 32'h0000_7000, 1, 3, 1, 0, 2);
    drive("R7 breakpoint", 1, 18, 0, 0, 32'h0000_8008, 1, 2, 1, 0, 3);
    drive("R8 irq in debug", 1, 0, 0, 2, 32'h0000_9000, 1, 1, 1, 1, 1);
    drive("R11 unsupported code", 1, 40, 7, 0, 32'hDEAD_0000, 0, 3, 1, 0, 2);
    drive("R11 code 19 edge", 1, 19, 1, 0, 32'hBEEF_0000, 1, 2, 1, 0, 1);
    drive("R12 idle hold", 0, 11, 3, 9, 32'hFFFF_FFF0, 1, 3, 1, 1, 5);
    drive("R12 idle hold 2", 0, 18, 0, 0, 32'h1111_1110, 0, 0, 0, 0, 0);
    drive("R9 R5 fp error vs7", 1, 17, 2, 0, 32'h0000_A000, 0, 0, 1, 0, 7);
    drive("R10 irq vs7", 1, 0, 0, 31, 32'h0000_B000, 0, 2, 0, 0, 7);
    drive("R9 vs0 bound", 1, 10, 0, 0, 32'h0000_C000, 0, 1, 0, 0, 0);
    drive("R12 final idle", 0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule